// File: doc/BRIEF.md
# Gated 16-bit Down-Counting Timer Channel

This block is one timer channel that counts down from a programmed reload value. Each count step is taken on a tick. A tick comes from one of eight clock sources, passed through a divide-by-1/2/4/8 prescaler. All sources are single-cycle enable strobes in the system clock domain, except for one external clock line, which is edge-detected.

A host programs the channel through a simple write port. Address 0 holds the reload value and address 1 holds the control word. The gate input has two meanings, set by the mode:
- In the one-shot, rate and square-wave modes, the gate is a level enable that is active low.
- In the retriggerable one-shot mode, a rising edge on the gate loads the counter and starts it.

The channel drives a polarity-selectable timer output. It also raises a one-cycle terminal-count pulse that an interrupt controller can latch. The current count is visible on a port.

Top module: `gate_timer16`

## Requirements
- R1: After reset, count_o is 0, timer_o is 0 and tc_o is 0. The control word resets to all zeros: stopped, mode 0, source 0, prescale 1, no inversion.
- R2: A write with wr_addr_i=1 updates the control word. The fields are: bit 0 start, bits 2:1 mode, bits 5:3 source, bits 7:6 prescale exponent, bit 8 invert. Writing start=1 copies the reload register into the count in every mode and clears the logical output. A write with wr_addr_i=0 changes only the reload register; a count in progress keeps its value.
- R3: Source 0 is the rising edge of ext_tck_i: one strobe per low-to-high change, however long the line stays high. Source k (1..7) is int_stb_i[k-1]. Strobes on unselected sources have no effect.
- R4: With prescale exponent p, a count step occurs on every 2^p-th strobe of the selected source. Strobes are counted from the last control write.
- R5: In modes 0, 1 and 2, no count step occurs while gate_i is high.
- R6: Mode 0 (one-shot): at terminal count, the count goes to 0, counting stops and the logical output becomes active. The output stays active until the next control write.
- R7: Mode 1 (rate): at terminal count, the count reloads and the logical output is active. The output goes inactive again at the next count step.
- R8: Mode 2 (square wave): at terminal count, the count reloads and the logical output toggles.
- R9: Mode 3 (retriggerable one-shot): start=1 only arms the channel. Each rising edge of gate_i while armed reloads the count and makes the output active, including edges that arrive during a run. The gate level is ignored. At terminal count, the count goes to 0, the output goes inactive and counting stops.
- R10: Terminal count is a count step taken while the count is 1 or 0, so a reload of 0 acts as 1. Each terminal count gives tc_o high for exactly the following cycle.
- R11: timer_o equals the logical output when invert is 0 and its complement when invert is 1.
- R12: Writing the control word with start=0 stops the channel. Later strobes leave the count unchanged and the logical output is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 = reload value, 1 = control word |
| wr_data_i | input | 16 | Write data |
| ext_tck_i | input | 1 | External timer clock level (source 0, rising edge counts) |
| int_stb_i | input | 7 | Internal clock-enable strobes (sources 1..7) |
| gate_i | input | 1 | Level enable (active low) in modes 0-2, edge trigger in mode 3 |
| count_o | output | 16 | Current count value |
| timer_o | output | 1 | Timer output after polarity selection |
| tc_o | output | 1 | One-cycle terminal-count pulse |

## Verification
The hardest state to reach from the ports is a prescaler phase that lines up with a particular count value. Strobes from the wrong source must not shift that phase, and a retrigger edge must land while a retriggerable run is still in progress. The stimulus table therefore drives the exact strobe pattern cycle by cycle. It mixes strobes from selected and unselected sources under a divide-by-two prescaler, and it raises the gate mid-count in mode 3 so that a retrigger happens before terminal count. Directed tests then cover the divide-by-eight external clock with wide high pulses, a reload of zero, and a reload value changed while the channel is running.

// File: rtl/gtm_pkg.sv
package gtm_pkg;
  localparam int N_SRC = 8;
  localparam int SEL_W = $clog2(N_SRC);
  localparam int PRE_W = 2;
  localparam int N_INT = N_SRC - 1;

  typedef enum logic [1:0] {
    MODE_ONESHOT = 2'd0,
    MODE_RATE    = 2'd1,
    MODE_SQUARE  = 2'd2,
    MODE_RETRIG  = 2'd3
  } gtm_mode_e;

  typedef struct packed {
    logic             inv;
    logic [PRE_W-1:0] presc;
    logic [SEL_W-1:0] src;
    gtm_mode_e        mode;
    logic             start;
  } gtm_ctrl_t;

  localparam int CTRL_W = $bits(gtm_ctrl_t);
endpackage

// File: rtl/gtm_regs.sv
module gtm_regs
  import gtm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] reload_o,
  output gtm_ctrl_t        ctrl_o,
  output gtm_ctrl_t        ctrl_new_o,
  output logic             ctrl_wr_o
);
  logic unused_hi;

  assign ctrl_new_o = gtm_ctrl_t'(wr_data_i[CTRL_W-1:0]);
  assign ctrl_wr_o  = wr_en_i & wr_addr_i;
  assign unused_hi  = ^wr_data_i[CNT_W-1:CTRL_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_o <= '0;
      ctrl_o   <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i) ctrl_o   <= ctrl_new_o;
      else           reload_o <= wr_data_i;
    end
  end
endmodule

// File: rtl/gtm_clk_sel.sv
module gtm_clk_sel
  import gtm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_tck_i,
  input  logic [N_INT-1:0] int_stb_i,
  input  logic [SEL_W-1:0] src_i,
  input  logic [PRE_W-1:0] presc_i,
  input  logic             clr_i,
  output logic             sel_stb_o,
  output logic             tick_o
);
  localparam int PCNT_W = (1 << PRE_W) - 1;

  logic              ext_q;
  logic [N_SRC-1:0]  srcs;
  logic [PCNT_W-1:0] pcnt_q;
  logic [PCNT_W-1:0] mask;

  assign srcs      = {int_stb_i, ext_tck_i & ~ext_q};
  assign sel_stb_o = srcs[src_i];

  always_comb begin
    for (int i = 0; i < PCNT_W; i++) mask[i] = (i < int'(presc_i));
  end

  assign tick_o = sel_stb_o & ((pcnt_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_q  <= 1'b0;
      pcnt_q <= '0;
    end else begin
      ext_q <= ext_tck_i;
      if (clr_i)          pcnt_q <= '0;
      else if (sel_stb_o) pcnt_q <= pcnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/gtm_gate.sv
module gtm_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  output logic en_o,
  output logic trig_o
);
  logic gate_q;

  assign en_o   = ~gate_i;
  assign trig_o = gate_i & ~gate_q;

  // reset high: no false trigger on a gate already high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b1;
    else         gate_q <= gate_i;
  end
endmodule

// File: rtl/gtm_core.sv
module gtm_core
  import gtm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] reload_i,
  input  gtm_mode_e        mode_i,
  input  logic             ctrl_wr_i,
  input  logic             new_start_i,
  input  gtm_mode_e        new_mode_i,
  input  logic             tick_i,
  input  logic             gate_en_i,
  input  logic             trig_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             act_o,
  output logic             tc_o
);
  logic run_q, armed_q;
  logic step, term;

  assign step = run_q & tick_i & ((mode_i == MODE_RETRIG) | gate_en_i);
  assign term = (cnt_o <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o   <= '0;
      act_o   <= 1'b0;
      tc_o    <= 1'b0;
      run_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      tc_o <= 1'b0;
      if (ctrl_wr_i) begin
        act_o   <= 1'b0;
        armed_q <= new_start_i;
        run_q   <= new_start_i & (new_mode_i != MODE_RETRIG);
        if (new_start_i) cnt_o <= reload_i;
      end else if (trig_i && armed_q && mode_i == MODE_RETRIG) begin
        cnt_o <= reload_i;
        run_q <= 1'b1;
        act_o <= 1'b1;
      end else if (step) begin
        if (term) begin
          tc_o <= 1'b1;
          unique case (mode_i)
            MODE_ONESHOT: begin cnt_o <= '0;       run_q <= 1'b0; act_o <= 1'b1;   end
            MODE_RATE:    begin cnt_o <= reload_i;                act_o <= 1'b1;   end
            MODE_SQUARE:  begin cnt_o <= reload_i;                act_o <= ~act_o; end
            MODE_RETRIG:  begin cnt_o <= '0;       run_q <= 1'b0; act_o <= 1'b0;   end
            default:      ;
          endcase
        end else begin
          cnt_o <= cnt_o - 1'b1;
          if (mode_i == MODE_RATE) act_o <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/gate_timer16.sv
module gate_timer16
  import gtm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             ext_tck_i,
  input  logic [N_INT-1:0] int_stb_i,
  input  logic             gate_i,
  output logic [CNT_W-1:0] count_o,
  output logic             timer_o,
  output logic             tc_o
);
  logic [CNT_W-1:0] reload;
  gtm_ctrl_t        ctrl_q, ctrl_new;
  logic             ctrl_wr, sel_stb, tick, gate_en, trig, act;

  gtm_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .reload_o(reload), .ctrl_o(ctrl_q), .ctrl_new_o(ctrl_new), .ctrl_wr_o(ctrl_wr)
  );

  gtm_clk_sel u_clk_sel (
    .clk_i, .rst_ni, .ext_tck_i, .int_stb_i,
    .src_i(ctrl_q.src), .presc_i(ctrl_q.presc), .clr_i(ctrl_wr),
    .sel_stb_o(sel_stb), .tick_o(tick)
  );

  gtm_gate u_gate (
    .clk_i, .rst_ni, .gate_i, .en_o(gate_en), .trig_o(trig)
  );

  gtm_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni,
    .reload_i(reload), .mode_i(ctrl_q.mode),
    .ctrl_wr_i(ctrl_wr), .new_start_i(ctrl_new.start), .new_mode_i(ctrl_new.mode),
    .tick_i(tick), .gate_en_i(gate_en), .trig_i(trig),
    .cnt_o(count_o), .act_o(act), .tc_o
  );

  assign timer_o = act ^ ctrl_q.inv;
endmodule

// File: rtl/gtm_chk.sv
module gtm_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             gate_i,
  input logic             tick_i,
  input logic             sel_stb_i,
  input logic             start_i,
  input logic [1:0]       mode_i,
  input logic             inv_i,
  input logic [CNT_W-1:0] count_o,
  input logic             timer_o,
  input logic             tc_o
);
  // R10
  tc_after_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> $past(tick_i && count_o <= CNT_W'(1)));

  // R4
  tick_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> sel_stb_i);

  // R12
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !wr_en_i) |=> $stable(count_o));

  // R12
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |-> (timer_o == inv_i));

  // R5
  gate_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && mode_i != 2'd3 && gate_i && !wr_en_i) |=> $stable(count_o));

  // R6
  oneshot_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o && mode_i == 2'd0) |-> (count_o == '0 && timer_o == !inv_i));

  // R9
  retrig_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o && mode_i == 2'd3) |-> (count_o == '0 && timer_o == inv_i));
endmodule

bind gate_timer16 gtm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .gate_i(gate_i),
  .tick_i(tick), .sel_stb_i(sel_stb), .start_i(ctrl_q.start),
  .mode_i(ctrl_q.mode), .inv_i(ctrl_q.inv),
  .count_o(count_o), .timer_o(timer_o), .tc_o(tc_o)
);

// File: tb/gate_timer16_tb.sv
module gate_timer16_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic        addr = 1'b0;
  logic [15:0] data = '0;
  logic        ext = 1'b0;
  logic [6:0]  stb = '0;
  logic        gate = 1'b0;
  logic [15:0] count;
  logic        tmr, tc;
  int          errors = 0;
  int          checks = 0;
  int          tc_seen = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  gate_timer16 u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .wr_addr_i(addr), .wr_data_i(data),
    .ext_tck_i(ext), .int_stb_i(stb), .gate_i(gate),
    .count_o(count), .timer_o(tmr), .tc_o(tc)
  );

  always @(negedge clk) if (tc) tc_seen++;

  // {we, addr, data[16], stb[7], gate, exp_count[16], exp_timer, exp_tc}
  localparam int NV = 32;
  localparam logic [43:0] VEC [NV] = '{
    // R6 R5 mode 0, source 1, reload 3
    {1'b1,1'b0,16'd3,    7'h00,1'b0, 16'd0,1'b0,1'b0},
    {1'b1,1'b1,16'h0009, 7'h00,1'b0, 16'd3,1'b0,1'b0},
    {1'b0,1'b0,16'd0,    7'h01,1'b0, 16'd2,1'b0,1'b0},
    {1'b0,1'b0,16'd0,    7'h00,1'b0, 16'd2,1'b0,1'b0},
    {1'b0,1'b0,16'd0,    7'h01,1'b1, 16'd2,1'b0,1'b0},
    {1'b0,1'b0,16'd0,    7'h01,1'b0, 16'd1,1'b0,1'b0},
    {1'b0,1'b0,16'd0,    7'h01,1'b0, 16'd0,1'b1,1'b1},
    {1'b0,1'b0,16'd0,    7'h01,1'b0, 16'd0,1'b1,1'b0},
    // R7 R4 R3 R11 mode 1, source 2, divide by 2, inverted, reload 2
    {1'b1,1'b0,16'd2,    7'h00,1'b0, 16'd0,1'b1,1'b0},
    {1'b1,1'b1,16'h0153, 7'h00,1'b0, 16'd2,1'b1,1'b0},
    {1'b0,1'b0,16'd0,    7'h02,1'b0, 16'd2,1'b1,1'b0},
    {1'b0,1'b0,16'd0,    7'h02,1'b0, 16'd1,1'b1,1'b0},
    {1'b0,1'b0,16'd0,    7'h01,1'b0, 16'd1,1'b1,1'b0},
    {1'b0,1'b0,16'd0,    7'h02,1'b0, 16'd1,1'b1,1'b0},
    {1'b0,1'b0,16'd0,    7'h02,1'b0, 16'd2,1'b0,1'b1},
    {1'b0,1'b0,16'd0,    7'h02,1'b0, 16'd2,1'b0,1'b0},
    {1'b0,1'b0,16'd0,    7'h02,1'b0, 16'd1,1'b1,1'b0},
    // R8 mode 2, source 3
    {1'b1,1'b1,16'h001D, 7'h00,1'b0, 16'd2,1'b0,1'b0},
    {1'b0,1'b0,16'd0,    7'h04,1'b0, 16'd1,1'b0,1'b0},
    {1'b0,1'b0,16'd0,    7'h04,1'b0, 16'd2,1'b1,1'b1},
    {1'b0,1'b0,16'd0,    7'h04,1'b0, 16'd1,1'b1,1'b0},
    {1'b0,1'b0,16'd0,    7'h04,1'b1, 16'd1,1'b1,1'b0},
    {1'b0,1'b0,16'd0,    7'h04,1'b0, 16'd2,1'b0,1'b1},
    // R9 mode 3, source 1, retrigger
    {1'b1,1'b1,16'h000F, 7'h00,1'b0, 16'd2,1'b0,1'b0},
    {1'b0,1'b0,16'd0,    7'h01,1'b0, 16'd2,1'b0,1'b0},
    {1'b0,1'b0,16'd0,    7'h00,1'b1, 16'd2,1'b1,1'b0},
    {1'b0,1'b0,16'd0,    7'h01,1'b1, 16'd1,1'b1,1'b0},
    {1'b0,1'b0,16'd0,    7'h00,1'b0, 16'd1,1'b1,1'b0},
    {1'b0,1'b0,16'd0,    7'h00,1'b1, 16'd2,1'b1,1'b0},
    {1'b0,1'b0,16'd0,    7'h01,1'b1, 16'd1,1'b1,1'b0},
    {1'b0,1'b0,16'd0,    7'h01,1'b1, 16'd0,1'b0,1'b1},
    {1'b0,1'b0,16'd0,    7'h01,1'b1, 16'd0,1'b0,1'b0}
  };

  function automatic string req_of(int i);
    if (i < 8)  return "R6/R5";
    if (i < 17) return "R7/R4/R3/R11";
    if (i < 23) return "R8/R5";
    return "R9/R10";
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic state_chk(input string req, input int c, input int t, input int p);
    chk(req, "count_o", int'(count), c);
    chk(req, "timer_o", int'(tmr), t);
    chk(req, "tc_o", int'(tc), p);
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    we = 1'b1; addr = a; data = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic pulse(input logic [6:0] m);
    stb = m;
    @(negedge clk);
    stb = '0;
  endtask

  task automatic ext_pulse();
    ext = 1'b1;
    repeat (3) @(negedge clk);
    ext = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    state_chk("R1", 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    state_chk("R1", 0, 0, 0);

    for (int i = 0; i < NV; i++) begin
      we = VEC[i][43]; addr = VEC[i][42]; data = VEC[i][41:26];
      stb = VEC[i][25:19]; gate = VEC[i][18];
      @(negedge clk);
      state_chk(req_of(i), int'(VEC[i][17:2]), int'(VEC[i][1]), int'(VEC[i][0]));
    end
    we = 1'b0; stb = '0; gate = 1'b0;

    // R10 reload 0 behaves as 1
    wr(1'b0, 16'd0);
    wr(1'b1, 16'h0009);
    state_chk("R10", 0, 0, 0);
    pulse(7'h01);
    state_chk("R10", 0, 1, 1);

    // R2 reload written while running applies at the next reload
    wr(1'b0, 16'd2);
    wr(1'b1, 16'h000B);
    wr(1'b0, 16'd4);
    state_chk("R2", 2, 0, 0);
    pulse(7'h01);
    state_chk("R2", 1, 0, 0);
    pulse(7'h01);
    state_chk("R2", 4, 1, 1);

    // R12 stop freezes the count and clears the output
    wr(1'b1, 16'h000A);
    state_chk("R12", 4, 0, 0);
    pulse(7'h01);
    pulse(7'h01);
    state_chk("R12", 4, 0, 0);

    // R3 R4 external clock edges, divide by 8, wide high pulses
    wr(1'b0, 16'd1);
    wr(1'b1, 16'h00C3);
    tc_seen = 0;
    repeat (7) ext_pulse();
    chk("R3/R4", "tc count after 7 edges", tc_seen, 0);
    ext_pulse();
    chk("R3/R4", "tc count after 8 edges", tc_seen, 1);
    chk("R7", "count_o after reload", int'(count), 1);

    // R1 reset during a run
    wr(1'b1, 16'h0009);
    rst_n = 1'b0;
    @(negedge clk);
    state_chk("R1", 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule